// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data without processor involvement. It handles memory to memory, port to memory and port to port copies over a simple bus with a single master. The bus uses a request/grant pair plus read and write strobes. Each channel is loaded in a single cycle with the following settings:

- a source address and a destination address;
- a transfer count;
- a unit size;
- an increment-or-hold choice for each address;
- a bus-hold mode;
- a software start bit.

A channel that is loaded without the start bit stays armed until its external request line rises.

Every transfer is a read cycle followed by a write cycle. Only one channel owns the engine at a time. A global mode input chooses between fixed priority and round-robin arbitration. When a channel finishes, or stops on a bad address, it sets its own pending interrupt. The interrupt is gated by a per-channel enable and cleared by a per-channel strobe.

Top module: `dma2ch`

## Requirements
- R1: A started channel performs exactly count transfers. Each transfer is one bus_rd cycle that captures bus_rdata, followed directly by one bus_wr cycle that drives the captured value on bus_wdata. After reset, bus_req, irq and err are all 0.
- R2: With rr_mode=0 and both channels running, channel 0 is served first every time. Channel 1 moves only after channel 0 has finished.
- R3: With rr_mode=1 and both channels running, the channel served most recently gets the lowest priority. Two channels in cycle-steal mode therefore alternate. Right after reset, channel 0 wins the first contest.
- R4: A count field of 0 means 2^CNT_W transfers, which is 65,536 at the default width.
- R5: The size code sets the unit: 0 is a byte, 1 is 16 bits, 2 is 32 bits. Data sits in the low bits of the bus, little-endian, and bus_size carries the code. An incrementing address advances by 1, 2 or 4.
- R6: In cycle-steal mode (ld_burst=0), bus_req falls after every write cycle, so each transfer makes one request. In burst mode, bus_req stays high from the first read until the last write.
- R7: A channel loaded with ld_sw=0 makes no bus request until its ext_req bit is seen high.
- R8: A channel is stopped with err set, pending set and no bus cycle in these cases: a source or destination address is not a multiple of the unit, or the size code is 3. A later load of that channel clears its err bit.
- R9: irq[c] is pending[c] AND irq_en[c]. Pending stays set while masked and shows as soon as the mask opens. A pulse on irq_clr[c] clears it.
- R10: An address whose increment bit is 0 stays fixed for the whole operation.
- R11: A load aimed at a channel that is still armed or running is ignored, including its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load strobe for one channel's settings |
| ld_ch | input | 1 | Channel being loaded |
| ld_src | input | AW | Source start address |
| ld_dst | input | AW | Destination start address |
| ld_cnt | input | CNT_W | Transfer count, 0 meaning 2^CNT_W |
| ld_size | input | 2 | Unit size code |
| ld_src_inc | input | 1 | Source address increments |
| ld_dst_inc | input | 1 | Destination address increments |
| ld_burst | input | 1 | Hold the bus for the whole count |
| ld_sw | input | 1 | Start at once (software request) |
| ext_req | input | 2 | External start request per channel |
| rr_mode | input | 1 | 1 selects round-robin, 0 fixed priority |
| irq_en | input | 2 | Interrupt enable per channel |
| irq_clr | input | 2 | Clear pending interrupt per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Address of the current cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_size | output | 2 | Unit size code of the current cycle |
| bus_wdata | output | DW | Write data, low-aligned |
| bus_rdata | input | DW | Read data, valid in the bus_rd cycle |
| irq | output | 2 | Per-channel interrupt |
| err | output | 2 | Per-channel address error flag |

## Verification
The assertions rely on the bus keeping bus_gnt high from the moment it grants until bus_req falls. They also rely on bus_rdata being valid combinationally in the cycle bus_rd is high. The bench's grant model follows both rules: it waits a random number of cycles before granting and releases only when the request drops. Its memory answers reads at once. Random source and destination addresses are always aligned to the unit, so error paths arise only from the directed misaligned loads. Source and destination regions never overlap.

// File: rtl/dma2ch.sv
module dma2ch #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_ch,
  input  logic [AW-1:0]    ld_src,
  input  logic [AW-1:0]    ld_dst,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic [1:0]       ld_size,
  input  logic             ld_src_inc,
  input  logic             ld_dst_inc,
  input  logic             ld_burst,
  input  logic             ld_sw,
  input  logic [1:0]       ext_req,
  input  logic             rr_mode,
  input  logic [1:0]       irq_en,
  input  logic [1:0]       irq_clr,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [1:0]       bus_size,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic [1:0]       irq,
  output logic [1:0]       err
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} st_t;

  st_t              state;
  logic [AW-1:0]    src_q   [2];
  logic [AW-1:0]    dst_q   [2];
  logic [CNT_W-1:0] cnt_q   [2];
  logic [1:0]       size_q  [2];
  logic [1:0]       sinc_q, dinc_q, burst_q;
  logic [1:0]       armed, run, pend, err_q;
  logic             cur, last, pick, bad;
  logic [DW-1:0]    data_q;

  function automatic logic misal(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      2'd0:    misal = 1'b0;
      2'd1:    misal = a[0];
      2'd2:    misal = |a;
      default: misal = 1'b1;
    endcase
  endfunction

  function automatic logic [AW-1:0] step(input logic [1:0] sz);
    step = AW'(1) << sz;
  endfunction

  always_comb begin
    if (run == 2'b11) pick = rr_mode ? ~last : 1'b0;
    else              pick = ~run[0];
    bad = misal(size_q[pick], src_q[pick][1:0]) | misal(size_q[pick], dst_q[pick][1:0]);
  end

  assign bus_req   = (state != S_IDLE);
  assign bus_rd    = (state == S_RD);
  assign bus_wr    = (state == S_WR);
  assign bus_addr  = bus_wr ? dst_q[cur] : src_q[cur];
  assign bus_size  = size_q[cur];
  assign bus_wdata = data_q;
  assign irq       = pend & irq_en;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sinc_q  <= '0;
      dinc_q  <= '0;
      burst_q <= '0;
      armed   <= '0;
      run     <= '0;
      pend    <= '0;
      err_q   <= '0;
      cur     <= 1'b0;
      last    <= 1'b1;
      data_q  <= '0;
      for (int c = 0; c < 2; c++) begin
        src_q[c]  <= '0;
        dst_q[c]  <= '0;
        cnt_q[c]  <= '0;
        size_q[c] <= '0;
      end
    end else begin
      pend <= pend & ~irq_clr;
      if (ld_valid && !armed[ld_ch]) begin
        src_q[ld_ch]   <= ld_src;
        dst_q[ld_ch]   <= ld_dst;
        cnt_q[ld_ch]   <= ld_cnt;
        size_q[ld_ch]  <= ld_size;
        sinc_q[ld_ch]  <= ld_src_inc;
        dinc_q[ld_ch]  <= ld_dst_inc;
        burst_q[ld_ch] <= ld_burst;
        armed[ld_ch]   <= 1'b1;
        run[ld_ch]     <= ld_sw;
        err_q[ld_ch]   <= 1'b0;
      end
      for (int c = 0; c < 2; c++)
        if (armed[c] && !run[c] && ext_req[c]) run[c] <= 1'b1;
      case (state)
        S_IDLE: if (|run) begin
          if (bad) begin
            run[pick]   <= 1'b0;
            armed[pick] <= 1'b0;
            err_q[pick] <= 1'b1;
            pend[pick]  <= 1'b1;
          end else begin
            cur   <= pick;
            state <= S_REQ;
          end
        end
        S_REQ: if (bus_gnt) state <= S_RD;
        S_RD: begin
          data_q <= bus_rdata;
          state  <= S_WR;
        end
        S_WR: begin
          if (sinc_q[cur]) src_q[cur] <= src_q[cur] + step(size_q[cur]);
          if (dinc_q[cur]) dst_q[cur] <= dst_q[cur] + step(size_q[cur]);
          cnt_q[cur] <= cnt_q[cur] - CNT_W'(1);
          last       <= cur;
          if (cnt_q[cur] == CNT_W'(1)) begin
            run[cur]   <= 1'b0;
            armed[cur] <= 1'b0;
            pend[cur]  <= 1'b1;
            state      <= S_IDLE;
          end else begin
            state <= burst_q[cur] ? S_RD : S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd));
  p_owned_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_gnt && bus_req));
  p_steal_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !burst_q[cur]) |=> !bus_req);
  p_aligned_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !misal(bus_size, bus_addr[1:0]));
  p_fixed_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && run == 2'b11 && !rr_mode && !bad) |=> (state == S_REQ && cur == 1'b0));
  p_rr_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && run == 2'b11 && rr_mode && !bad) |=> (cur != $past(last)));

endmodule

// File: tb/tb_dma2ch.sv
module tb_dma2ch;
  localparam int AW = 32, DW = 32, CW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_ch = 0, ld_src_inc = 0, ld_dst_inc = 0, ld_burst = 0, ld_sw = 0;
  logic [AW-1:0] ld_src = '0, ld_dst = '0;
  logic [CW-1:0] ld_cnt = '0;
  logic [1:0] ld_size = '0, ext_req = '0, irq_en = 2'b11, irq_clr = '0;
  logic rr_mode = 0;
  logic bus_req, bus_rd, bus_wr, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_size, irq, err;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  int rises = 0, nlog = 0;
  logic req_d = 0;
  logic [63:0] wlog;
  logic [7:0] mem [4096];
  logic [7:0] sh  [4096];

  always #2 clk = ~clk;

  dma2ch #(.AW(AW), .DW(DW), .CNT_W(CW)) dut (
    .clk, .rst_n, .ld_valid, .ld_ch, .ld_src, .ld_dst, .ld_cnt, .ld_size,
    .ld_src_inc, .ld_dst_inc, .ld_burst, .ld_sw, .ext_req, .rr_mode, .irq_en,
    .irq_clr, .bus_req, .bus_gnt, .bus_addr, .bus_rd, .bus_wr, .bus_size,
    .bus_wdata, .bus_rdata, .irq, .err);

  always_comb begin
    logic [11:0] a;
    a = bus_addr[11:0];
    bus_rdata = {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
    if (bus_size == 2'd0) bus_rdata = bus_rdata & 32'h0000_00FF;
    else if (bus_size == 2'd1) bus_rdata = bus_rdata & 32'h0000_FFFF;
  end

  always @(posedge clk) begin
    if (bus_wr) begin
      mem[bus_addr[11:0]] <= bus_wdata[7:0];
      if (bus_size >= 2'd1) mem[bus_addr[11:0] + 12'd1] <= bus_wdata[15:8];
      if (bus_size >= 2'd2) begin
        mem[bus_addr[11:0] + 12'd2] <= bus_wdata[23:16];
        mem[bus_addr[11:0] + 12'd3] <= bus_wdata[31:24];
      end
      wlog[nlog[5:0]] <= bus_addr[10];
      nlog <= nlog + 1;
    end
    if (bus_req && !req_d) rises <= rises + 1;
    req_d <= bus_req;
  end

  logic gnt_q = 1'b0;
  assign bus_gnt = gnt_q;
  always @(posedge clk) begin
    if (!bus_req) gnt_q <= 1'b0;
    else if (!gnt_q && ($urandom % 3 != 0)) gnt_q <= 1'b1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load(input bit ch, input int src, input int dst, input int cnt,
                      input int sz, input bit si, input bit di, input bit burst, input bit sw);
    @(negedge clk);
    ld_valid = 1; ld_ch = ch; ld_src = AW'(src); ld_dst = AW'(dst); ld_cnt = CW'(cnt);
    ld_size = 2'(sz); ld_src_inc = si; ld_dst_inc = di; ld_burst = burst; ld_sw = sw;
    @(negedge clk);
    ld_valid = 0; ld_sw = 0;
  endtask

  task automatic model(input int src, input int dst, input int cnt, input int sz,
                       input bit si, input bit di);
    int n, s, d;
    logic [7:0] tmp [4];
    n = (cnt == 0) ? (1 << CW) : cnt;
    s = src; d = dst;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < (1 << sz); b++) tmp[b] = sh[(s + b) & 12'hFFF];
      for (int b = 0; b < (1 << sz); b++) sh[(d + b) & 12'hFFF] = tmp[b];
      if (si) s += (1 << sz);
      if (di) d += (1 << sz);
    end
  endtask

  task automatic wait_irq(input logic [1:0] want, input string tag);
    int t = 0;
    while ((irq & want) != want && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check((irq & want) == want, tag, irq, want);
    irq_clr = want;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== sh[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0, tag, first, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, n0, seed;
    seed = $urandom(1234);
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom);
      sh[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(bus_req == 0 && irq == 0 && err == 0, "R1 reset state", {bus_req, irq, err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 fixed priority
    rr_mode = 0;
    load(0, 'h000, 'h800, 3, 0, 1, 1, 0, 0);
    load(1, 'h100, 'hC00, 3, 0, 1, 1, 0, 0);
    model('h000, 'h800, 3, 0, 1, 1);
    model('h100, 'hC00, 3, 0, 1, 1);
    n0 = nlog;
    ext_req = 2'b11;
    wait_irq(2'b11, "R2 both done");
    ext_req = 0;
    for (int k = 0; k < 6; k++)
      check(wlog[(n0 + k) % 64] == (k >= 3), "R2 fixed order", wlog[(n0 + k) % 64], k >= 3);
    cmp_mem("R2 data");

    // R3 round robin
    rr_mode = 1;
    load(0, 'h010, 'h810, 3, 1, 1, 1, 0, 0);
    load(1, 'h110, 'hC10, 3, 1, 1, 1, 0, 0);
    model('h010, 'h810, 3, 1, 1, 1);
    model('h110, 'hC10, 3, 1, 1, 1);
    n0 = nlog;
    ext_req = 2'b11;
    wait_irq(2'b11, "R3 both done");
    ext_req = 0;
    for (int k = 0; k < 6; k++)
      check(wlog[(n0 + k) % 64] == k[0], "R3 alternation", wlog[(n0 + k) % 64], k[0]);
    cmp_mem("R3 data");

    // R1 R5 R6 R10 random transfers
    for (int it = 0; it < 12; it++) begin
      int sz, cnt, src, dst;
      bit ch, si, di, bu;
      sz  = $urandom % 3;
      cnt = 1 + $urandom % 8;
      src = ($urandom % 64) << 2;
      dst = 'h800 + (($urandom % 64) << 2);
      ch  = 1'($urandom);
      si  = 1'($urandom);
      di  = 1'($urandom);
      bu  = 1'($urandom);
      r0 = rises;
      n0 = nlog;
      load(ch, src, dst, cnt, sz, si, di, bu, 1);
      model(src, dst, cnt, sz, si, di);
      wait_irq(ch ? 2'b10 : 2'b01, "R1 completion");
      @(negedge clk);
      check(nlog - n0 == cnt, "R1 transfer count", nlog - n0, cnt);
      check(rises - r0 == (bu ? 1 : cnt), "R6 request count", rises - r0, bu ? 1 : cnt);
      cmp_mem("R5 R10 random data");
    end

    // R10 directed: fixed port destination, word units
    load(0, 'h200, 'h900, 4, 2, 1, 0, 1, 1);
    model('h200, 'h900, 4, 2, 1, 0);
    wait_irq(2'b01, "R10 done");
    cmp_mem("R10 fixed destination");

    // R7 external start
    r0 = rises;
    load(1, 'h300, 'hD00, 5, 1, 1, 1, 0, 0);
    repeat (40) @(negedge clk);
    check(rises == r0, "R7 idle until ext_req", rises - r0, 0);
    ext_req = 2'b10;
    @(negedge clk);
    ext_req = 0;
    model('h300, 'hD00, 5, 1, 1, 1);
    wait_irq(2'b10, "R7 done");
    cmp_mem("R7 data");

    // R8 alignment errors
    r0 = rises;
    load(0, 'h001, 'h800, 2, 1, 1, 1, 0, 1);
    repeat (4) @(negedge clk);
    check(err == 2'b01 && irq[0], "R8 misaligned source", {err, irq}, 4'b0101);
    load(1, 'h004, 'h802, 2, 2, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
    check(err == 2'b11 && irq[1], "R8 misaligned word dest", {err, irq}, 4'b1111);
    irq_clr = 2'b11;
    @(negedge clk);
    irq_clr = 0;
    load(0, 'h000, 'h800, 1, 3, 1, 1, 0, 1);
    repeat (4) @(negedge clk);
    check(err[0] && irq[0], "R8 size code 3", {err, irq}, 4'b1101);
    check(rises == r0, "R8 no bus cycles", rises - r0, 0);
    irq_clr = 2'b11;
    @(negedge clk);
    irq_clr = 0;
    load(0, 'h000, 'h800, 1, 0, 1, 1, 0, 0);
    check(err[0] == 0, "R8 load clears err", err[0], 0);
    ext_req = 2'b01;
    @(negedge clk);
    ext_req = 0;
    model('h000, 'h800, 1, 0, 1, 1);
    wait_irq(2'b01, "R8 recovery");

    // R9 masking
    irq_en = 2'b00;
    load(0, 'h020, 'h820, 2, 0, 1, 1, 1, 1);
    model('h020, 'h820, 2, 0, 1, 1);
    repeat (40) @(negedge clk);
    check(irq == 2'b00, "R9 masked", irq, 0);
    irq_en = 2'b01;
    #0;
    check(irq == 2'b01, "R9 unmasked pending", irq, 1);
    irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 0;
    check(irq == 2'b00, "R9 cleared", irq, 0);
    irq_en = 2'b11;

    // R11 load while armed ignored
    r0 = rises;
    load(0, 'h040, 'h840, 3, 0, 1, 1, 0, 0);
    load(0, 'h040, 'hA00, 3, 0, 1, 1, 0, 1);
    repeat (20) @(negedge clk);
    check(rises == r0, "R11 second load ignored", rises - r0, 0);
    ext_req = 2'b01;
    @(negedge clk);
    ext_req = 0;
    model('h040, 'h840, 3, 0, 1, 1);
    wait_irq(2'b01, "R11 done");
    cmp_mem("R11 data");

    // R4 count zero means full range
    n0 = nlog;
    load(1, 'h000, 'h400, 0, 0, 1, 1, 1, 1);
    model('h000, 'h400, 0, 0, 1, 1);
    wait_irq(2'b10, "R4 done");
    @(negedge clk);
    check(nlog - n0 == (1 << CW), "R4 zero count", nlog - n0, 1 << CW);
    cmp_mem("R4 data");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule